// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which of a bank of transmit mailboxes goes out next on a CAN-style bus. The host queues a mailbox by writing a one to its bit in a request-set vector. Each mailbox has an enable bit, a direction bit and a 6-bit priority value. Only enabled mailboxes whose direction bit marks them as transmit can compete for selection. The winner is the pending mailbox with the largest priority value. When two or more mailboxes share that value, the highest mailbox number wins.

The choice is recomputed every cycle. It is captured into the output register only while the bus-idle input is high, so the mailbox on the wire stays fixed for the whole frame. A completion strobe during a frame sets that mailbox's acknowledge bit and retires its request. The host can withdraw a queued request that has not started, which raises an abort bit for that mailbox. The host clears acknowledge and abort bits by writing ones to them. A global mailbox flag is raised while any acknowledged mailbox has its interrupt mask bit set.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, `sel_valid_o`, `gmif_o` and every bit of `req_o`, `ack_o` and `abt_o` are 0.
- R2: Among eligible pending mailboxes, the one whose 6-bit field in `mb_prio_i` (mailbox i at bits 6i+5:6i) is numerically largest is selected.
- R3: When several eligible pending mailboxes share the largest priority value, the highest-numbered one is selected.
- R4: A mailbox is eligible only if its request bit is set, `mb_en_i[i]` is 1 and `mb_dir_i[i]` is 0 (0 = transmit, 1 = receive). Pending requests on other mailboxes never win.
- R5: `sel_valid_o`/`sel_idx_o` load the current choice on a clock edge where `bus_idle_i` is 1, and hold their values on every edge where it is 0.
- R6: On an edge where `bus_idle_i` is 1 and no mailbox is eligible, `sel_valid_o` becomes 0.
- R7: A one in `req_set_i[i]` sets `req_o[i]` on the next edge, and this set wins over any clear in the same cycle. A `tx_done_i` pulse while a frame is in flight (`sel_valid_o`=1, `bus_idle_i`=0) sets the acknowledge bit of `sel_idx_o` and clears its request bit. A pulse outside a frame has no effect.
- R8: A one in `ack_clr_i[i]` clears `ack_o[i]`. A completion on the same mailbox in the same cycle wins over the clear.
- R9: A one in `req_rst_i[i]` clears a pending `req_o[i]` and sets `abt_o[i]`, unless mailbox i is the one in flight. An in-flight request is unaffected. A withdrawn mailbox is excluded from the selection loaded on that same edge. A one in `abt_clr_i[i]` clears `abt_o[i]`.
- R10: `gmif_o` is 1 exactly when some mailbox has both its acknowledge bit and its `irq_mask_i` bit set.

Port table. MB_NUM = 32 and PRIO_W = 6 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mb_en_i | input | MB_NUM | Per-mailbox enable |
| mb_dir_i | input | MB_NUM | Per-mailbox direction, 0 = transmit |
| mb_prio_i | input | MB_NUM*PRIO_W | Packed priority fields |
| irq_mask_i | input | MB_NUM | Per-mailbox interrupt mask |
| req_set_i | input | MB_NUM | Write-one request set |
| req_rst_i | input | MB_NUM | Write-one request withdraw |
| ack_clr_i | input | MB_NUM | Write-one acknowledge clear |
| abt_clr_i | input | MB_NUM | Write-one abort clear |
| bus_idle_i | input | 1 | Bus free, selection may be loaded |
| tx_done_i | input | 1 | Completion strobe for the mailbox in flight |
| sel_valid_o | output | 1 | Selected mailbox is valid |
| sel_idx_o | output | $clog2(MB_NUM) | Selected mailbox index |
| req_o | output | MB_NUM | Pending request bits |
| ack_o | output | MB_NUM | Transmit acknowledge bits |
| abt_o | output | MB_NUM | Abort acknowledge bits |
| gmif_o | output | 1 | Global mailbox interrupt flag |

## Verification
Several input patterns exercise selection:
- A single request checks the basic capture of the choice.
- Two mailboxes with equal priority separate the number tie-break from the priority compare.
- High-priority requests on a receive mailbox and on a disabled mailbox check that eligibility gating comes before the compare.
- A higher-priority request that arrives mid-frame must not replace the mailbox in flight until the bus goes idle. This separates the hold from the recompute.

Other patterns cover the bit vectors:
- Withdrawals are tried on the in-flight mailbox and on idle mailboxes.
- A completion strobe is sent outside a frame.
- An acknowledge clear is sent in the same cycle as a completion.

These patterns separate the precedence rules and the masking of the interrupt flag.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int unsigned MB_NUM_DEF = 32;
  localparam int unsigned PRIO_W_DEF = 6;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int unsigned MB_NUM = 32,
  parameter int unsigned PRIO_W = 6,
  localparam int unsigned IDX_W = txmb_pkg::idx_w(MB_NUM)
) (
  input  logic [MB_NUM-1:0]        elig_i,
  input  logic [MB_NUM*PRIO_W-1:0] prio_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with >= : equal priority lets the higher index take over
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < MB_NUM; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] >= best)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/txmb_flags.sv
module txmb_flags #(
  parameter int unsigned MB_NUM = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MB_NUM-1:0] req_set_i,
  input  logic [MB_NUM-1:0] withdraw_i,
  input  logic [MB_NUM-1:0] done_i,
  input  logic [MB_NUM-1:0] ack_clr_i,
  input  logic [MB_NUM-1:0] abt_clr_i,
  output logic [MB_NUM-1:0] req_o,
  output logic [MB_NUM-1:0] ack_o,
  output logic [MB_NUM-1:0] abt_o
);
  for (genvar i = 0; i < MB_NUM; i++) begin : g_mb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_o[i] <= 1'b0;
        ack_o[i] <= 1'b0;
        abt_o[i] <= 1'b0;
      end else begin
        req_o[i] <= (req_o[i] & ~withdraw_i[i] & ~done_i[i]) | req_set_i[i];
        ack_o[i] <= (ack_o[i] & ~ack_clr_i[i]) | done_i[i];
        abt_o[i] <= (abt_o[i] & ~abt_clr_i[i]) | withdraw_i[i];
      end
    end
  end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
  parameter int unsigned MB_NUM = txmb_pkg::MB_NUM_DEF,
  parameter int unsigned PRIO_W = txmb_pkg::PRIO_W_DEF,
  localparam int unsigned IDX_W = txmb_pkg::idx_w(MB_NUM)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [MB_NUM-1:0]        mb_en_i,
  input  logic [MB_NUM-1:0]        mb_dir_i,
  input  logic [MB_NUM*PRIO_W-1:0] mb_prio_i,
  input  logic [MB_NUM-1:0]        irq_mask_i,
  input  logic [MB_NUM-1:0]        req_set_i,
  input  logic [MB_NUM-1:0]        req_rst_i,
  input  logic [MB_NUM-1:0]        ack_clr_i,
  input  logic [MB_NUM-1:0]        abt_clr_i,
  input  logic                     bus_idle_i,
  input  logic                     tx_done_i,
  output logic                     sel_valid_o,
  output logic [IDX_W-1:0]         sel_idx_o,
  output logic [MB_NUM-1:0]        req_o,
  output logic [MB_NUM-1:0]        ack_o,
  output logic [MB_NUM-1:0]        abt_o,
  output logic                     gmif_o
);
  logic              sel_valid_q;
  logic [IDX_W-1:0]  sel_idx_q;
  logic              in_flight;
  logic [MB_NUM-1:0] fly_oh, withdraw, done_oh, elig;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;

  assign in_flight = sel_valid_q & ~bus_idle_i;

  always_comb begin
    fly_oh = '0;
    if (in_flight) fly_oh[sel_idx_q] = 1'b1;
  end

  assign withdraw = req_rst_i & req_o & ~fly_oh;
  assign done_oh  = tx_done_i ? fly_oh : '0;
  // withdrawals of this cycle are already out of the running
  assign elig     = req_o & ~withdraw & mb_en_i & ~mb_dir_i;

  txmb_pick #(.MB_NUM(MB_NUM), .PRIO_W(PRIO_W)) u_pick (
    .elig_i (elig),
    .prio_i (mb_prio_i),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  txmb_flags #(.MB_NUM(MB_NUM)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_set_i  (req_set_i),
    .withdraw_i (withdraw),
    .done_i     (done_oh),
    .ack_clr_i  (ack_clr_i),
    .abt_clr_i  (abt_clr_i),
    .req_o      (req_o),
    .ack_o      (ack_o),
    .abt_o      (abt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
    end else if (bus_idle_i) begin
      sel_valid_q <= pick_any;
      sel_idx_q   <= pick_idx;
    end
  end

  assign sel_valid_o = sel_valid_q;
  assign sel_idx_o   = sel_idx_q;
  assign gmif_o      = |(ack_o & irq_mask_i);
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk #(
  parameter int unsigned MB_NUM = 32,
  localparam int unsigned IDX_W = txmb_pkg::idx_w(MB_NUM)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MB_NUM-1:0] req_set_i,
  input logic [MB_NUM-1:0] req_rst_i,
  input logic [MB_NUM-1:0] ack_clr_i,
  input logic              bus_idle_i,
  input logic              tx_done_i,
  input logic              sel_valid_o,
  input logic [IDX_W-1:0]  sel_idx_o,
  input logic [MB_NUM-1:0] req_o,
  input logic [MB_NUM-1:0] ack_o,
  input logic [MB_NUM-1:0] abt_o
);
  a_r5_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_idle_i |=> $stable(sel_valid_o) && $stable(sel_idx_o));

  a_r6_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && req_o == '0) |=> !sel_valid_o);

  a_r7_done_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && !bus_idle_i && tx_done_i) |=> ack_o[$past(sel_idx_o)]);

  a_r7_set_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_set_i != '0) |=> ((req_o & $past(req_set_i)) == $past(req_set_i)));

  a_r8_ack_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_valid_o && !bus_idle_i && tx_done_i) |=> ((ack_o & $past(ack_clr_i)) == '0));

  a_r9_abort_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_idle_i && (req_rst_i & req_o) != '0)
      |=> ((abt_o & $past(req_rst_i & req_o)) == $past(req_rst_i & req_o)));
endmodule

bind txmb_arbiter txmb_arbiter_chk #(.MB_NUM(MB_NUM)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_set_i   (req_set_i),
  .req_rst_i   (req_rst_i),
  .ack_clr_i   (ack_clr_i),
  .bus_idle_i  (bus_idle_i),
  .tx_done_i   (tx_done_i),
  .sel_valid_o (sel_valid_o),
  .sel_idx_o   (sel_idx_o),
  .req_o       (req_o),
  .ack_o       (ack_o),
  .abt_o       (abt_o)
);

// File: tb/txmb_arbiter_bench.sv
`timescale 1ns/1ps
module txmb_arbiter_bench;
  localparam int N  = 32;
  localparam int PW = 6;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    en, dir, mask, rset, rrst, aclr, bclr;
  logic [N*PW-1:0] prio_flat;
  logic [PW-1:0]   pr [N];
  logic            idle, done;
  logic            sel_v, gmif;
  logic [IW-1:0]   sel_i;
  logic [N-1:0]    req, ack, abt;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = pr[i];

  txmb_arbiter u_txmb_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .mb_en_i(en), .mb_dir_i(dir),
    .mb_prio_i(prio_flat), .irq_mask_i(mask), .req_set_i(rset),
    .req_rst_i(rrst), .ack_clr_i(aclr), .abt_clr_i(bclr),
    .bus_idle_i(idle), .tx_done_i(done), .sel_valid_o(sel_v),
    .sel_idx_o(sel_i), .req_o(req), .ack_o(ack), .abt_o(abt), .gmif_o(gmif)
  );

  typedef struct {
    logic v; int idx; logic [N-1:0] rq, ak, ab; logic gf; string tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0;
  bit finished = 0;
  logic m_v; int m_idx;
  logic [N-1:0] m_req, m_ack, m_abt;

  task automatic chk(input logic ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(sel_v === e.v, e.tag, "sel_valid", longint'(sel_v), longint'(e.v));
    if (e.v) chk(int'(sel_i) == e.idx, e.tag, "sel_idx", longint'(sel_i), longint'(e.idx));
    chk(req === e.rq, e.tag, "req", longint'(req), longint'(e.rq));
    chk(ack === e.ak, e.tag, "ack", longint'(ack), longint'(e.ak));
    chk(abt === e.ab, e.tag, "abt", longint'(abt), longint'(e.ab));
    chk(gmif === e.gf, e.tag, "gmif", longint'(gmif), longint'(e.gf));
  endtask

  // monitor: compare everything pushed before the edge just after it
  always @(posedge clk) begin
    exp_t e;
    #1;
    while (sbq.size() > 0) begin
      e = sbq.pop_front();
      compare(e);
    end
  end

  // reference: descending scan, strict compare (ties keep the higher number)
  function automatic int ref_pick(input logic [N-1:0] el);
    int w = -1;
    for (int i = N-1; i >= 0; i--)
      if (el[i] && (w < 0 || pr[i] > pr[w])) w = i;
    return w;
  endfunction

  function automatic logic [N-1:0] b(input int i);
    logic [N-1:0] r = '0;
    r[i] = 1'b1;
    return r;
  endfunction

  task automatic step(input logic [N-1:0] s, r, ac, bc, input logic dn, input string tag);
    logic in_fl; logic [N-1:0] wd, doh; int w; exp_t e;
    in_fl = m_v && !idle;
    doh = '0;
    if (dn && in_fl) doh[m_idx] = 1'b1;
    wd = r & m_req;
    if (in_fl) wd[m_idx] = 1'b0;
    rset = s; rrst = r; aclr = ac; bclr = bc; done = dn;
    if (idle) begin
      w = ref_pick(m_req & ~wd & en & ~dir);
      m_v = (w >= 0);
      if (w >= 0) m_idx = w;
    end
    m_req = (m_req & ~wd & ~doh) | s;
    m_ack = (m_ack & ~ac) | doh;
    m_abt = (m_abt & ~bc) | wd;
    e.v = m_v; e.idx = m_idx; e.rq = m_req; e.ak = m_ack; e.ab = m_abt;
    e.gf = |(m_ack & mask); e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
    @(negedge clk);
    rset = '0; rrst = '0; aclr = '0; bclr = '0; done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [N-1:0] Z = '0;

  initial begin
    exp_t e0;
    en = '1; en[25] = 1'b0;
    dir = '0; dir[20] = 1'b1;
    mask = b(12);
    for (int i = 0; i < N; i++) pr[i] = '0;
    pr[3] = 6'd5; pr[10] = 6'd9; pr[12] = 6'd9; pr[20] = 6'd63;
    pr[25] = 6'd63; pr[30] = 6'd40; pr[5] = 6'd1;
    rset = '0; rrst = '0; aclr = '0; bclr = '0; done = 1'b0; idle = 1'b1;
    m_v = 1'b0; m_idx = 0; m_req = '0; m_ack = '0; m_abt = '0;
    repeat (3) @(negedge clk);
    e0.v = 1'b0; e0.idx = 0; e0.rq = '0; e0.ak = '0; e0.ab = '0; e0.gf = 1'b0;
    e0.tag = "R1 reset";
    compare(e0);
    rst_n = 1'b1;
    @(negedge clk);
    e0.tag = "R1 after release";
    compare(e0);

    step(b(3), Z, Z, Z, 0, "R7 request set");
    step(Z, Z, Z, Z, 0, "R2 single pick");
    step(b(10) | b(12), Z, Z, Z, 0, "R2 higher prio");
    step(Z, Z, Z, Z, 0, "R3 tie high index");
    step(b(20) | b(25), Z, Z, Z, 0, "R4 ineligible set");
    step(Z, Z, Z, Z, 0, "R4 ineligible ignored");
    step(Z, Z, Z, Z, 1, "R7 done ignored when idle");
    idle = 1'b0;
    step(b(30), Z, Z, Z, 0, "R5 late high prio");
    step(Z, Z, Z, Z, 0, "R5 hold while busy");
    step(Z, b(12), Z, Z, 0, "R9 in-flight kept");
    step(Z, Z, Z, Z, 1, "R7 R10 completion");
    idle = 1'b1;
    step(Z, Z, Z, Z, 0, "R5 reload on idle");
    step(Z, Z, b(12), Z, 0, "R8 ack clear");
    step(Z, b(30), Z, Z, 0, "R9 withdraw excluded");
    step(Z, Z, Z, b(30), 0, "R9 abort clear");
    step(Z, b(3) | b(10), Z, Z, 0, "R6 none eligible");
    step(b(5), Z, Z, Z, 0, "R7 set low prio");
    step(Z, Z, Z, Z, 0, "R2 low prio pick");
    idle = 1'b0;
    step(Z, Z, Z, Z, 0, "R5 busy");
    step(Z, Z, b(5), Z, 1, "R8 set wins R10 masked");
    idle = 1'b1;
    step(Z, Z, Z, Z, 0, "R6 empty again");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule